// File: doc/BRIEF.md
# Accumulator Cell Operand Selector

This block is the operand-fetch stage of one accumulator-based execution cell. Each cycle it may take in one 16-bit instruction half. It decodes the operand mode and the 8-bit value field of that instruction half and produces the n-bit second operand for the cell's ALU. That operand comes from one of three sources: a sign-extended immediate, a read of the cell's local word memory, or a co-operand broadcast to the cell from outside.

The cell keeps one local address register, which serves as the base for the relative modes. Only the post-updating relative mode writes that register. The local memory sits inside the block. It has one registered read port, used by the operand path, and one write port, through which the memory is loaded. The result appears one clock edge after the instruction is sampled, and the opcode travels alongside it so that the ALU stage receives both in the same cycle.

Top module: `acc_operand_fetch`

## Requirements
- R1: Bit fields of `instr`: opcode in [15:11], operand mode in [10:8], value in [7:0]. The opcode of an accepted instruction appears on `op_code` together with its operand.
- R2: Mode 0 (immediate): the operand is the 8-bit value sign-extended to DATA_W bits.
- R3: Mode 1 (absolute): the operand is mem[value mod 2^AW].
- R4: Mode 2 (base-relative): the operand is mem[(value + addr) mod 2^AW]. The address register is left unchanged.
- R5: Mode 3 (relative, post-update): the operand is mem[(value + addr) mod 2^AW], and the address register becomes (value + addr) mod 2^AW. The next instruction already sees the new address.
- R6: Mode 4 (co-operand): the operand is the `coop` input as sampled with the instruction.
- R7: Mode 5 (co-operand absolute): the operand is mem[coop mod 2^AW].
- R8: Mode 6 (co-operand relative): the operand is mem[(value + coop) mod 2^AW].
- R9: Mode 7 (control): no operand is produced. `op_valid` stays low, `operand` is zero and the address register is unchanged.
- R10: `op_valid` is high exactly one cycle after a cycle in which `instr_valid` was high with a data mode (0 to 6). Otherwise it is low, and `operand` is zero. Back-to-back instructions give back-to-back results.
- R11: Synchronous active-low reset clears the address register to 0 and drives `op_valid` and `operand` to 0.
- R12: When `mem_wr_en` is high, `mem_wr_data` is written to mem[`mem_wr_addr`] at the clock edge. Reads issued afterwards return the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | An instruction half is presented this cycle |
| instr | input | 16 | Instruction half: opcode, operand mode, value |
| coop | input | DATA_W | Broadcast co-operand |
| mem_wr_en | input | 1 | Local memory write strobe |
| mem_wr_addr | input | AW | Local memory write address |
| mem_wr_data | input | DATA_W | Local memory write data |
| op_valid | output | 1 | The operand is valid this cycle |
| op_code | output | 5 | Opcode that travels with the operand |
| operand | output | DATA_W | Second operand for the ALU |

## Verification
Every operand, its valid flag and its opcode are due exactly one rising edge after the edge that samples the instruction. A post-updated address affects the instruction sampled at the following edge. The bench therefore drives each instruction at a falling edge and reads the results at the next falling edge. For back-to-back sequences, it checks one result and presents the next instruction at that same falling edge. Memory loads through the write port are completed at least one edge before any read that depends on them.

// File: rtl/opsel_pkg.sv
// Shared encodings for the operand selector.
// Assumes the instruction half layout: opcode[15:11], mode[10:8], value[7:0].
package opsel_pkg;
    localparam int OPC_W   = 5;
    localparam int MODE_W  = 3;
    localparam int VAL_W   = 8;
    localparam int INSTR_W = OPC_W + MODE_W + VAL_W;

    typedef enum logic [MODE_W-1:0] {
        MD_IMM      = 3'd0,
        MD_ABS      = 3'd1,
        MD_REL      = 3'd2,
        MD_RELINC   = 3'd3,
        MD_COOP     = 3'd4,
        MD_COOP_ABS = 3'd5,
        MD_COOP_REL = 3'd6,
        MD_CTRL     = 3'd7
    } opmode_e;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        opmode_e          mode;
        logic [VAL_W-1:0] val;
    } instr_t;
endpackage

// File: rtl/opsel_decode.sv
// Combinational decode of one instruction half.
// Produces the memory read request, the non-memory operand, the
// address register update and the fire flag. Assumes DATA_W >= AW
// and DATA_W >= 8.
module opsel_decode
    import opsel_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AW     = 6
) (
    input  logic              valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [AW-1:0]     addr_cur,
    input  logic [DATA_W-1:0] coop,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    output logic              use_mem,
    output logic [DATA_W-1:0] direct_data,
    output logic              upd_en,
    output logic [AW-1:0]     upd_val,
    output logic              fire,
    output logic [OPC_W-1:0]  opc
);
    instr_t        ins;
    logic [AW-1:0] val_a;
    logic [AW-1:0] coop_a;
    logic [AW-1:0] rel_a;

    assign ins    = instr_t'(instr);
    assign opc    = ins.opc;
    assign val_a  = AW'(ins.val);
    assign coop_a = AW'(coop);
    assign rel_a  = val_a + addr_cur;

    // Select the operand source and address for the decoded mode.
    always_comb begin
        rd_addr     = '0;
        use_mem     = 1'b0;
        direct_data = '0;
        upd_en      = 1'b0;
        upd_val     = rel_a;
        fire        = valid;
        case (ins.mode)
            MD_IMM:      direct_data = DATA_W'($signed(ins.val));
            MD_ABS:      begin use_mem = 1'b1; rd_addr = val_a; end
            MD_REL:      begin use_mem = 1'b1; rd_addr = rel_a; end
            MD_RELINC:   begin use_mem = 1'b1; rd_addr = rel_a; upd_en = valid; end
            MD_COOP:     direct_data = coop;
            MD_COOP_ABS: begin use_mem = 1'b1; rd_addr = coop_a; end
            MD_COOP_REL: begin use_mem = 1'b1; rd_addr = val_a + coop_a; end
            default:     fire = 1'b0;
        endcase
    end

    assign rd_en = valid && use_mem;
endmodule

// File: rtl/opsel_addr_reg.sv
// Local address register of the cell.
// It changes only when a post-updating relative instruction is accepted.
// Assumes a synchronous active-low reset.
module opsel_addr_reg #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_en,
    input  logic [AW-1:0] upd_val,
    output logic [AW-1:0] addr_q
);
    // Hold the base address; load on the post-update mode.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (upd_en) addr_q <= upd_val;
    end

    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(addr_q));
    assert_addr_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> addr_q == $past(upd_val));
endmodule

// File: rtl/opsel_lmem.sv
// Local word memory of the cell: one write port and one registered read port.
// A read and a write to the same word in the same cycle return the old word.
module opsel_lmem #(
    parameter int DATA_W = 32,
    parameter int AW     = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a word from the write port.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Registered read for the operand path.
    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/acc_operand_fetch.sv
// Operand-fetch stage of an accumulator execution cell.
// Decodes an instruction half and returns the ALU's second operand
// with one cycle of latency. The opcode travels alongside the operand.
// Assumes a synchronous active-low reset and DATA_W >= max(AW, 8).
module acc_operand_fetch
    import opsel_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AW     = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  coop,
    input  logic               mem_wr_en,
    input  logic [AW-1:0]      mem_wr_addr,
    input  logic [DATA_W-1:0]  mem_wr_data,
    output logic               op_valid,
    output logic [OPC_W-1:0]   op_code,
    output logic [DATA_W-1:0]  operand
);
    logic              rd_en, use_mem, upd_en, fire;
    logic [AW-1:0]     rd_addr, upd_val, addr_q;
    logic [DATA_W-1:0] direct_data, rd_data;
    logic [OPC_W-1:0]  opc;

    logic              valid_q, use_mem_q;
    logic [DATA_W-1:0] direct_q;
    logic [OPC_W-1:0]  opc_q;

    opsel_decode #(.DATA_W(DATA_W), .AW(AW)) u_dec (
        .valid(instr_valid), .instr(instr), .addr_cur(addr_q), .coop(coop),
        .rd_en(rd_en), .rd_addr(rd_addr), .use_mem(use_mem),
        .direct_data(direct_data), .upd_en(upd_en), .upd_val(upd_val),
        .fire(fire), .opc(opc)
    );

    opsel_addr_reg #(.AW(AW)) u_areg (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_val(upd_val),
        .addr_q(addr_q)
    );

    opsel_lmem #(.DATA_W(DATA_W), .AW(AW)) u_mem (
        .clk(clk), .wr_en(mem_wr_en), .wr_addr(mem_wr_addr),
        .wr_data(mem_wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    // Align the non-memory operand, source choice and opcode with the read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            use_mem_q <= 1'b0;
            direct_q  <= '0;
            opc_q     <= '0;
        end else begin
            valid_q   <= fire;
            use_mem_q <= use_mem;
            direct_q  <= direct_data;
            opc_q     <= opc;
        end
    end

    assign op_valid = valid_q;
    assign op_code  = opc_q;
    assign operand  = !valid_q ? '0 : (use_mem_q ? rd_data : direct_q);

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[10:8] != 3'd7) |=> op_valid);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> (!op_valid && operand == '0));
    assert_ctrl_no_operand_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[10:8] == 3'd7) |=> (!op_valid && operand == '0));
    assert_imm_sext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[10:8] == 3'd0) |=>
            operand == DATA_W'($signed($past(instr[7:0]))));
    assert_coop_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[10:8] == 3'd4) |=> operand == $past(coop));
    assert_opcode_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> op_code == $past(instr[15:11]));
endmodule

// File: tb/acc_operand_fetch_test.sv
`timescale 1ns/1ps
module acc_operand_fetch_test;
    localparam int DW = 32;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          instr_valid;
    logic [15:0]   instr;
    logic [DW-1:0] coop;
    logic          mem_wr_en;
    logic [AW-1:0] mem_wr_addr;
    logic [DW-1:0] mem_wr_data;
    logic          op_valid;
    logic [4:0]    op_code;
    logic [DW-1:0] operand;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    acc_operand_fetch #(.DATA_W(DW), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .coop(coop), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .op_valid(op_valid), .op_code(op_code),
        .operand(operand)
    );

    function automatic logic [DW-1:0] pat(int i);
        return 32'hA500_0000 + 32'(i) * 32'd17;
    endfunction

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one instruction at a falling edge; leaves the bench at the next falling edge.
    task automatic put(logic [4:0] opc, logic [2:0] md, logic [7:0] v, logic [DW-1:0] c);
        instr_valid = 1'b1;
        instr = {opc, md, v};
        coop = c;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic expect_op(string tag, logic [4:0] opc, logic [DW-1:0] exp);
        chk({tag, " valid"}, 32'(op_valid), 32'd1);
        chk({tag, " opcode R1"}, 32'(op_code), 32'(opc));
        chk(tag, operand, exp);
    endtask

    task automatic t_reset_r11();
        chk("R11 op_valid after reset", 32'(op_valid), 0);
        chk("R11 operand after reset", operand, 0);
        put(5'd1, 3'd2, 8'd0, 0);
        expect_op("R11 addr starts at 0", 5'd1, pat(0));
    endtask

    task automatic t_fill_r12();
        for (int i = 0; i < (1 << AW); i++) begin
            mem_wr_en = 1'b1; mem_wr_addr = AW'(i); mem_wr_data = pat(i);
            @(negedge clk);
        end
        mem_wr_en = 1'b0;
    endtask

    task automatic t_imm_r2();
        put(5'd3, 3'd0, 8'h7F, 0);
        expect_op("R2 positive imm", 5'd3, 32'h0000_007F);
        put(5'd4, 3'd0, 8'h80, 0);
        expect_op("R2 negative imm", 5'd4, 32'hFFFF_FF80);
    endtask

    task automatic t_abs_r3();
        put(5'd5, 3'd1, 8'd5, 0);
        expect_op("R3 absolute", 5'd5, pat(5));
        put(5'd6, 3'd1, 8'hC5, 0);
        expect_op("R3 absolute wraps", 5'd6, pat(5));
    endtask

    task automatic t_rel_r4_r5();
        put(5'd7, 3'd2, 8'd9, 0);
        expect_op("R4 relative base 0", 5'd7, pat(9));
        put(5'd8, 3'd3, 8'd10, 0);
        expect_op("R5 post-update read", 5'd8, pat(10));
        put(5'd9, 3'd2, 8'd3, 0);
        expect_op("R5 new base used", 5'd9, pat(13));
        put(5'd9, 3'd2, 8'd3, 0);
        expect_op("R4 base unchanged by relative", 5'd9, pat(13));
        put(5'd10, 3'd3, 8'd60, 0);
        expect_op("R5 wraps sum", 5'd10, pat(6));
        put(5'd11, 3'd2, 8'd0, 0);
        expect_op("R5 wrapped base", 5'd11, pat(6));
    endtask

    task automatic t_ctrl_r9();
        put(5'd12, 3'd7, 8'd20, 32'h1234);
        chk("R9 control no valid", 32'(op_valid), 0);
        chk("R9 control zero operand", operand, 0);
        put(5'd13, 3'd2, 8'd0, 0);
        expect_op("R9 base unchanged by control", 5'd13, pat(6));
    endtask

    task automatic t_coop_r6_r7_r8();
        put(5'd14, 3'd4, 8'd1, 32'hDEAD_BEEF);
        expect_op("R6 co-operand", 5'd14, 32'hDEAD_BEEF);
        put(5'd15, 3'd5, 8'd0, 32'h0000_0107);
        expect_op("R7 co-operand absolute", 5'd15, pat(7));
        put(5'd16, 3'd6, 8'd2, 32'h0000_003E);
        expect_op("R8 co-operand relative wrap", 5'd16, pat(0));
        put(5'd17, 3'd6, 8'd4, 32'h0000_0010);
        expect_op("R8 co-operand relative", 5'd17, pat(20));
    endtask

    task automatic t_stream_r10();
        @(negedge clk);
        chk("R10 idle no valid", 32'(op_valid), 0);
        chk("R10 idle zero operand", operand, 0);
        instr_valid = 1'b1; instr = {5'd18, 3'd3, 8'd1}; coop = 0;
        @(negedge clk);
        expect_op("R10 first of burst", 5'd18, pat(7));
        instr = {5'd19, 3'd3, 8'd1};
        @(negedge clk);
        expect_op("R10 second of burst", 5'd19, pat(8));
        instr = {5'd20, 3'd0, 8'hFE};
        @(negedge clk);
        expect_op("R10 third of burst", 5'd20, 32'hFFFF_FFFE);
        instr_valid = 1'b0;
        @(negedge clk);
        chk("R10 valid drops", 32'(op_valid), 0);
    endtask

    task automatic t_write_r12();
        mem_wr_en = 1'b1; mem_wr_addr = 6'd5; mem_wr_data = 32'h0BAD_F00D;
        @(negedge clk);
        mem_wr_en = 1'b0;
        put(5'd21, 3'd1, 8'd5, 0);
        expect_op("R12 rewritten word", 5'd21, 32'h0BAD_F00D);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; instr_valid = 1'b0; instr = '0; coop = '0;
        mem_wr_en = 1'b0; mem_wr_addr = '0; mem_wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_fill_r12();
        t_reset_r11();
        t_imm_r2();
        t_abs_r3();
        t_rel_r4_r5();
        t_ctrl_r9();
        t_coop_r6_r7_r8();
        t_stream_r10();
        t_write_r12();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule